// File: doc/BRIEF.md
# Masked Time Alarm Interrupt Unit

This unit watches a running calendar clock and raises interrupts when it reaches programmed alarm times. It holds two alarm comparators. Each one has four byte fields: seconds, minutes, hours and weekday. Every time the clock's registers advance, the surrounding logic pulses `secTick` for one cycle, and the unit compares both alarms against the current time bytes during that cycle. If an alarm field has its top bit set, that field accepts any time value. This lets software build alarms that fire every minute, every hour, every day or once a week.

When an alarm matches, the unit sets a sticky pending flag for that alarm. Each alarm has an enable bit. An enabled pending flag pulls an active-low interrupt pin. The interrupt pin for alarm 0 is always the primary one. A routing bit in the control byte moves alarm 1 from the primary pin to a secondary pin. Software acknowledges a flag in one of two ways:

- reading any byte of that alarm's registers, or
- writing the status byte.

Register accesses arrive as single-cycle read and write strobes with a byte address. The serial transport that produces these strobes sits outside this unit.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset, all alarm bytes, the control byte and both pending flags read as zero, and both `irq0N` and `irq1N` are high.
- R2: Register map and read data.
  - Bytes 0x07..0x0A hold alarm 0 and bytes 0x0B..0x0E hold alarm 1, in the field order seconds, minutes, hours, weekday.
  - 0x0F is the control byte. Bit 0 is alarm 0 enable, bit 1 is alarm 1 enable, bit 2 is alarm 1 routing, and the other bits read zero.
  - 0x10 is the status byte. Bit 0 is the alarm 0 flag, bit 1 is the alarm 1 flag, and the other bits read zero.
  - `regRdata` shows the addressed byte combinationally in the cycle in which `regRd` is high.
- R3: Match rule for the flag set by a `secTick` cycle.
  - An alarm's flag sets at the clock edge that ends a `secTick` cycle when every field of that alarm matches.
  - A field matches when its bit 7 is set, or when the time byte equals the field's low seven bits with bit 7 zero.
  - Hours are compared as encoded bytes, so the 12-hour bit and the PM bit must agree.
  - No flag sets in a cycle without `secTick`.
- R4: A field with bit 7 set matches any time value. An alarm with all four fields set this way matches on every tick.
- R5: A pending flag stays set across idle cycles and later non-matching ticks.
- R6: Reading any byte of alarm k clears flag k at that clock edge. The other alarm's flag is left alone.
- R7: A write to 0x10 clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. Writing zero clears both flags.
- R8: If a match and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: `irq0N` is low exactly when (flag 0 and enable 0) or (flag 1 and enable 1 with routing bit 0).
- R10: `irq1N` is low exactly when flag 1, enable 1 and the routing bit are all set. Alarm 1 then has no effect on `irq0N`.
- R11: Clearing an enable bit releases the pin but leaves the flag set, and the flag stays readable in status.
- R12: Unmapped addresses read zero, and writes to them change nothing. Reads of control or status clear no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secTick | input | 1 | One-cycle pulse after the time bytes advance |
| curSec | input | 8 | Current seconds byte |
| curMin | input | 8 | Current minutes byte |
| curHour | input | 8 | Current hours byte (12/24-hour encoded) |
| curDay | input | 8 | Current weekday byte |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (alarm reads acknowledge) |
| regAddr | input | 5 | Register byte address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the addressed byte |
| irq0N | output | 1 | Primary interrupt, active low |
| irq1N | output | 1 | Secondary interrupt for routed alarm 1, active low |

## Verification
The bench aims at the places where set and clear meet:

- A tick that matches in the same cycle as an acknowledging read or a status write. A design with the wrong priority silently loses an alarm.
- Partial matches, where one field is off by one. A comparator that ORs the fields instead of ANDing them would fire early.
- The 12-hour bits in the hours field. Masking these bits would make a PM alarm fire at the matching AM time.
- The routing bit and the enable bits. Wrong routing shows up as alarm 1 asserting both pins. An enable that clears the flag shows up as a lost status bit.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 5;
  localparam int NUM_ALM     = 2;
  localparam int FIELDS      = 4;
  localparam int ALM_IDX_W   = (NUM_ALM > 1) ? $clog2(NUM_ALM) : 1;
  localparam int FIELD_IDX_W = $clog2(FIELDS);
  localparam int CTRL_W      = NUM_ALM + 1;

  localparam logic [ADDR_W-1:0] ALM_BASE  = 5'h07;
  localparam logic [ADDR_W-1:0] ALM_LIMIT = ALM_BASE + ADDR_W'(NUM_ALM * FIELDS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h0F;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 5'h10;

  typedef struct packed {
    logic                   almWr;
    logic                   almRd;
    logic [ALM_IDX_W-1:0]   almIdx;
    logic [FIELD_IDX_W-1:0] fieldIdx;
    logic                   ctrlWr;
    logic                   ctrlRd;
    logic                   statWr;
    logic                   statRd;
  } regStrobe_t;
endpackage

// File: rtl/alarm_field_match.sv
module alarm_field_match #(
  parameter int DATA_W = 8,
  parameter int FIELDS = 4
) (
  input  logic [FIELDS-1:0][DATA_W-1:0] almFields,
  input  logic [FIELDS-1:0][DATA_W-1:0] curFields,
  output logic                          hit
);
  logic [FIELDS-1:0] fieldOk;

  for (genvar f = 0; f < FIELDS; f++) begin : g_field
    logic anyValue;
    logic sameValue;
    assign anyValue  = almFields[f][DATA_W-1];
    assign sameValue = ({1'b0, almFields[f][DATA_W-2:0]} == curFields[f]);
    assign fieldOk[f] = anyValue | sameValue;
  end

  assign hit = &fieldOk;
endmodule

// File: rtl/alarm_reg_decode.sv
module alarm_reg_decode
  import alarm_irq_pkg::*;
(
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);
  logic              inAlm;
  logic [ADDR_W-1:0] off;

  always_comb begin
    inAlm = (regAddr >= ALM_BASE) && (regAddr < ALM_LIMIT);
    off   = regAddr - ALM_BASE;
    strb          = '0;
    strb.almIdx   = ALM_IDX_W'(off >> FIELD_IDX_W);
    strb.fieldIdx = FIELD_IDX_W'(off);
    strb.almWr    = regWr & inAlm;
    strb.almRd    = regRd & inAlm;
    strb.ctrlWr   = regWr & (regAddr == CTRL_ADDR);
    strb.ctrlRd   = regRd & (regAddr == CTRL_ADDR);
    strb.statWr   = regWr & (regAddr == STAT_ADDR);
    strb.statRd   = regRd & (regAddr == STAT_ADDR);
  end
endmodule

// File: rtl/alarm_irq_datapath.sv
module alarm_irq_datapath
  import alarm_irq_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int NA  = NUM_ALM,
  parameter int NF  = FIELDS,
  localparam int CW = NA + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  regStrobe_t                strb,
  input  logic [DW-1:0]             wdata,
  input  logic                      secTick,
  input  logic [NF-1:0][DW-1:0]     curTime,
  output logic [DW-1:0]             rdata,
  output logic [NA-1:0]             flags,
  output logic [CW-1:0]             ctrlBits,
  output logic                      irqPrimN,
  output logic                      irqSecN
);
  logic [NF-1:0][DW-1:0] almReg [NA];
  logic [NA-1:0]         hit;
  logic [NA-1:0]         pendEn;
  logic                  route;

  for (genvar a = 0; a < NA; a++) begin : g_alarm
    logic setNow;
    logic clrNow;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        almReg[a] <= '0;
      end else if (strb.almWr && strb.almIdx == ALM_IDX_W'(a)) begin
        almReg[a][strb.fieldIdx] <= wdata;
      end
    end

    alarm_field_match #(.DATA_W(DW), .FIELDS(NF)) u_match (
      .almFields(almReg[a]),
      .curFields(curTime),
      .hit      (hit[a])
    );

    // a match in the same cycle as an acknowledge wins, so no event is lost
    assign setNow = secTick & hit[a];
    assign clrNow = (strb.almRd && strb.almIdx == ALM_IDX_W'(a)) ||
                    (strb.statWr && !wdata[a]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       flags[a] <= 1'b0;
      else if (setNow) flags[a] <= 1'b1;
      else if (clrNow) flags[a] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ctrlBits <= '0;
    else if (strb.ctrlWr) ctrlBits <= wdata[CW-1:0];
  end

  assign pendEn   = flags & ctrlBits[NA-1:0];
  assign route    = ctrlBits[NA];
  assign irqPrimN = ~((|pendEn[NA-2:0]) | (pendEn[NA-1] & ~route));
  assign irqSecN  = ~(pendEn[NA-1] & route);

  always_comb begin
    rdata = '0;
    if (strb.almRd)       rdata = almReg[strb.almIdx][strb.fieldIdx];
    else if (strb.ctrlRd) rdata = DW'(ctrlBits);
    else if (strb.statRd) rdata = DW'(flags);
  end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [DATA_W-1:0] curSec,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curDay,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq0N,
  output logic              irq1N
);
  regStrobe_t                    strb;
  logic [NUM_ALM-1:0]            flagVec;
  logic [CTRL_W-1:0]             ctrlVec;
  logic [FIELDS-1:0][DATA_W-1:0] curTime;

  assign curTime = {curDay, curHour, curMin, curSec};

  alarm_reg_decode u_decode (
    .regWr  (regWr),
    .regRd  (regRd),
    .regAddr(regAddr),
    .strb   (strb)
  );

  alarm_irq_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (regWdata),
    .secTick (secTick),
    .curTime (curTime),
    .rdata   (regRdata),
    .flags   (flagVec),
    .ctrlBits(ctrlVec),
    .irqPrimN(irq0N),
    .irqSecN (irq1N)
  );
endmodule

// File: rtl/alarm_irq_checker.sv
module alarm_irq_checker
  import alarm_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              secTick,
  input logic              regWr,
  input logic              regRd,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              irq0N,
  input logic              irq1N,
  input logic [1:0]        flags,
  input logic [2:0]        ctrlBits
);
  logic rdAlm0;
  logic rdAlm1;
  assign rdAlm0 = regRd && regAddr >= 5'h07 && regAddr <= 5'h0A;
  assign rdAlm1 = regRd && regAddr >= 5'h0B && regAddr <= 5'h0E;

  assert_flag0_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[0]) |-> $past(secTick));
  assert_flag1_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[1]) |-> $past(secTick));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !regRd && !regWr) |=> $stable(flags));
  assert_read_ack0_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdAlm0 && !secTick) |=> !flags[0]);
  assert_read_ack1_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdAlm1 && !secTick) |=> !flags[1]);
  assert_status_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == STAT_ADDR && regWdata == '0 && !secTick) |=> (flags == 2'b00));
  assert_primary_pin_R9: assert property (@(posedge clk) disable iff (!rstN)
    !irq0N |-> ((flags[0] && ctrlBits[0]) || (flags[1] && ctrlBits[1] && !ctrlBits[2])));
  assert_secondary_pin_R10: assert property (@(posedge clk) disable iff (!rstN)
    !irq1N |-> (flags[1] && ctrlBits[1] && ctrlBits[2]));
endmodule

bind alarm_irq_unit alarm_irq_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .secTick (secTick),
  .regWr   (regWr),
  .regRd   (regRd),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .irq0N   (irq0N),
  .irq1N   (irq1N),
  .flags   (flagVec),
  .ctrlBits(ctrlVec)
);

// File: tb/test_alarm_irq_unit.sv
module test_alarm_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic [7:0] curSec = 8'h00, curMin = 8'h00, curHour = 8'h00, curDay = 8'h00;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       irq0N, irq1N;

  int nChecks = 0;
  int nErrors = 0;

  logic [7:0] mAlm [2][4];
  logic [2:0] mCtrl;
  logic [1:0] mFlag;

  always #(CLK_PERIOD / 2) clk = ~clk;

  alarm_irq_unit i_alarm_irq_unit (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDay(curDay),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq0N(irq0N), .irq1N(irq1N)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] timeByte(int f);
    case (f)
      0: return curSec;
      1: return curMin;
      2: return curHour;
      default: return curDay;
    endcase
  endfunction

  function automatic bit modelHit(int k);
    for (int f = 0; f < 4; f++) begin
      logic [7:0] a = mAlm[k][f];
      if (!a[7] && ({1'b0, a[6:0]} != timeByte(f))) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [7:0] modelRead(logic [4:0] addr);
    if (addr >= 5'h07 && addr <= 5'h0E) return mAlm[(addr - 7) / 4][(addr - 7) % 4];
    if (addr == 5'h0F) return {5'b0, mCtrl};
    if (addr == 5'h10) return {6'b0, mFlag};
    return 8'h00;
  endfunction

  // one clock of stimulus, with the model advanced and the pins compared
  task automatic step(logic wr, logic rd, logic [4:0] addr, logic [7:0] data,
                      logic tick, string tag);
    logic [1:0] setV, clrV;
    @(negedge clk);
    regWr = wr; regRd = rd; regAddr = addr; regWdata = data; secTick = tick;
    #1;
    if (rd) check(tag, regRdata, modelRead(addr));
    for (int k = 0; k < 2; k++) begin
      setV[k] = tick && modelHit(k);
      clrV[k] = (rd && addr >= 5'(7 + 4 * k) && addr <= 5'(10 + 4 * k)) ||
                (wr && addr == 5'h10 && !data[k]);
    end
    for (int k = 0; k < 2; k++)
      mFlag[k] = setV[k] ? 1'b1 : (clrV[k] ? 1'b0 : mFlag[k]);
    if (wr && addr >= 5'h07 && addr <= 5'h0E) mAlm[(addr - 7) / 4][(addr - 7) % 4] = data;
    if (wr && addr == 5'h0F) mCtrl = data[2:0];
    @(posedge clk);
    #1;
    check("R9", {7'b0, irq0N},
          {7'b0, ~((mFlag[0] & mCtrl[0]) | (mFlag[1] & mCtrl[1] & ~mCtrl[2]))});
    check("R10", {7'b0, irq1N}, {7'b0, ~(mFlag[1] & mCtrl[1] & mCtrl[2])});
    regWr = 1'b0; regRd = 1'b0; secTick = 1'b0;
  endtask

  task automatic wrReg(logic [4:0] a, logic [7:0] d, string tag);
    step(1'b1, 1'b0, a, d, 1'b0, tag);
  endtask
  task automatic rdReg(logic [4:0] a, string tag);
    step(1'b0, 1'b1, a, 8'h00, 1'b0, tag);
  endtask
  task automatic tickAt(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d, string tag);
    curSec = s; curMin = m; curHour = h; curDay = d;
    step(1'b0, 1'b0, 5'h00, 8'h00, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) for (int f = 0; f < 4; f++) mAlm[k][f] = 8'h00;
    mCtrl = '0; mFlag = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {6'b0, irq1N, irq0N}, 8'h03);
    @(negedge clk); rstN = 1'b1;
    for (int a = 7; a <= 16; a++) rdReg(5'(a), "R1");

    // program alarm 0 for 08:15:30 on any weekday, enable it
    wrReg(5'h07, 8'h30, "R2"); wrReg(5'h08, 8'h15, "R2");
    wrReg(5'h09, 8'h08, "R2"); wrReg(5'h0A, 8'h80, "R2");
    wrReg(5'h0F, 8'h01, "R2");
    for (int a = 7; a <= 15; a++) rdReg(5'(a), "R2");

    tickAt(8'h29, 8'h15, 8'h08, 8'h03, "R3"); rdReg(5'h10, "R3");
    tickAt(8'h30, 8'h16, 8'h08, 8'h03, "R3"); rdReg(5'h10, "R3");
    step(1'b0, 1'b0, 5'h00, 8'h00, 1'b0, "R3");
    tickAt(8'h30, 8'h15, 8'h08, 8'h05, "R4"); rdReg(5'h10, "R4");

    step(1'b0, 1'b0, 5'h00, 8'h00, 1'b0, "R5");
    tickAt(8'h31, 8'h15, 8'h08, 8'h05, "R5");
    rdReg(5'h10, "R5"); rdReg(5'h10, "R12"); rdReg(5'h0F, "R12");

    rdReg(5'h09, "R6"); rdReg(5'h10, "R6");

    // alarm 1 fires on every tick, shares the primary pin first
    for (int a = 11; a <= 14; a++) wrReg(5'(a), 8'h80, "R4");
    wrReg(5'h0F, 8'h03, "R9");
    tickAt(8'h00, 8'h00, 8'h00, 8'h01, "R4"); rdReg(5'h10, "R4");
    wrReg(5'h0F, 8'h07, "R10");
    rdReg(5'h08, "R6"); rdReg(5'h10, "R6");
    wrReg(5'h0F, 8'h04, "R11"); rdReg(5'h10, "R11");
    wrReg(5'h0F, 8'h07, "R11");

    tickAt(8'h30, 8'h15, 8'h08, 8'h02, "R7"); rdReg(5'h10, "R7");
    wrReg(5'h10, 8'h02, "R7"); rdReg(5'h10, "R7");
    wrReg(5'h10, 8'h00, "R7"); rdReg(5'h10, "R7");

    curSec = 8'h01;
    step(1'b0, 1'b1, 5'h0C, 8'h00, 1'b1, "R8"); rdReg(5'h10, "R8");
    step(1'b1, 1'b0, 5'h10, 8'h00, 1'b1, "R8"); rdReg(5'h10, "R8");

    // 12-hour encoded hours: 8 PM alarm must not fire at 8 AM
    wrReg(5'h10, 8'h00, "R3"); wrReg(5'h0E, 8'h01, "R3");
    wrReg(5'h09, 8'h68, "R3");
    tickAt(8'h30, 8'h15, 8'h48, 8'h03, "R3"); rdReg(5'h10, "R3");
    tickAt(8'h30, 8'h15, 8'h68, 8'h03, "R3"); rdReg(5'h10, "R3");

    wrReg(5'h11, 8'hFF, "R12"); wrReg(5'h06, 8'hFF, "R12"); wrReg(5'h1F, 8'hFF, "R12");
    rdReg(5'h11, "R12"); rdReg(5'h06, "R12");
    rdReg(5'h0F, "R12"); rdReg(5'h10, "R12");
    for (int a = 11; a <= 14; a++) rdReg(5'(a), "R12");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule